// File: doc/BRIEF.md
# Byte-Addressed Four-Mode Counter/Timer

This block counts one of three increment sources in a 16-bit register that software sees as a low byte and a high byte. The sources are falling edges on an asynchronous event pin, every system clock cycle, or a prescaled tick enable supplied from outside. Either byte can be loaded through a byte-wide write port, and both bytes can always be read. A two-bit mode field arranges the two bytes in one of four ways: a 13-bit counter, a full 16-bit counter, an 8-bit counter that reloads from the high byte, or two independent 8-bit counters.

Each rollover sets a sticky overflow flag. In split mode the high byte has a second flag of its own. Software clears both flags with a single pulse. An interrupt request is raised while any flag is set and the interrupt enable is high. Counting happens only while the run enable is high. A byte write takes priority over an increment in the same cycle.

Top module: `tmr_dual_byte`

## Requirements
- R1: After reset both count bytes read 0x00, both overflow flags are 0 and the interrupt request is 0.
- R2: With `evt_sel`=0, `sys_sel`=1 adds one per system clock cycle while running. With `evt_sel`=0, `sys_sel`=0 adds one per cycle in which `tick_en` is high.
- R3: With `evt_sel`=1, the event pin passes through a two-flop synchronizer. Each high-to-low transition held at least two cycles adds exactly one, and neither the system clock nor `tick_en` adds anything.
- R4: While `run_en` is 0 and no byte is written, both bytes and both flags hold their values.
- R5: In mode 0 (`mode_sel`=00), the count is 13 bits: the high byte is the upper 8 bits and low-byte bits 4..0 are the lower 5 bits. Stepping from 0x1FFF to 0x0000 sets `ovf_flag`. Low-byte bits 7..5 are don't-care.
- R6: In mode 1 (`mode_sel`=01), {high, low} counts as 16 bits, and stepping from 0xFFFF to 0x0000 sets `ovf_flag`.
- R7: In mode 2 (`mode_sel`=10), only the low byte counts. An increment at 0xFF loads the low byte from the high byte and sets `ovf_flag`. The high byte does not change.
- R8: In mode 3 (`mode_sel`=11), both bytes count on every increment. Low-byte wrap 0xFF to 0x00 sets `ovf_flag`, and high-byte wrap sets `ovf_hi_flag`.
- R9: `wr_lo` or `wr_hi` loads `wdata` into that byte on the next edge, and no increment is applied in that cycle.
- R10: `flag_clr` clears both flags. An overflow in the same cycle wins, and the flag it sets stays set.
- R11: `irq` is high exactly when `irq_en` is 1 and at least one overflow flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Prescaled tick enable |
| evt_pin | input | 1 | Asynchronous external event pin |
| run_en | input | 1 | Counting enable |
| mode_sel | input | 2 | Operating mode: 00 13-bit, 01 16-bit, 10 reload, 11 split |
| evt_sel | input | 1 | 1 = count event pin falling edges, 0 = timebase |
| sys_sel | input | 1 | Timebase choice: 1 = system clock, 0 = tick_en |
| irq_en | input | 1 | Interrupt request enable |
| wr_lo | input | 1 | Write strobe for the low byte |
| wr_hi | input | 1 | Write strobe for the high byte |
| wdata | input | 8 | Write data |
| flag_clr | input | 1 | Clears both overflow flags |
| rd_lo | output | 8 | Low byte of the count |
| rd_hi | output | 8 | High byte of the count |
| ovf_flag | output | 1 | Overflow flag (low byte in split mode) |
| ovf_hi_flag | output | 1 | High-byte overflow flag in split mode |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 5-bit low field in mode 0 and a two-stage synchronizer. With these settings, every rollover boundary is a few increments from a loadable preload value. Each mode is swept from several preload points across its wrap. The expected bytes and flags come from a bench model that steps each increment arithmetically. The short synchronizer keeps the latency from an event edge to the count a small fixed number of cycles, so pin-driven edge trains at the fastest allowed rate can be counted exactly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      TM_13B    = 2'b00,
      TM_16B    = 2'b01,
      TM_RELOAD = 2'b10,
      TM_SPLIT  = 2'b11
   } tmr_mode_e;
endpackage

// File: rtl/tmr_evt_sync.sv
module tmr_evt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic fall
);
   logic [STAGES-1:0] sh;
   logic              prev;

   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_evt_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[0] <= 1'b1;
            else        sh[0] <= pin;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[i] <= 1'b1;
            else        sh[i] <= sh[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= sh[STAGES-1];
   end

   assign fall = prev & ~sh[STAGES-1];

   // R3: a detected falling edge is a single-cycle pulse
   p_fall_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);
endmodule

// File: rtl/tmr_src_sel.sv
module tmr_src_sel (
   input  logic evt_fall,
   input  logic tick_en,
   input  logic run_en,
   input  logic evt_sel,
   input  logic sys_sel,
   output logic inc
);
   logic src;

   always_comb begin
      if (evt_sel)      src = evt_fall;
      else if (sys_sel) src = 1'b1;
      else              src = tick_en;
      inc = run_en & src;
   end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
   import tmr_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int M0_LO_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tmr_mode_e         mode,
   input  logic              inc,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              flag_clr,
   output logic [BYTE_W-1:0] lo,
   output logic [BYTE_W-1:0] hi,
   output logic              ovf,
   output logic              ovf_hi
);
   localparam int CNT_W = 2 * BYTE_W;
   localparam int M0_W  = BYTE_W + M0_LO_W;
   localparam logic [M0_W:0]   M0_ONE  = 1;
   localparam logic [CNT_W:0]  C16_ONE = 1;
   localparam logic [BYTE_W:0] B_ONE   = 1;

   if (M0_LO_W < 1 || M0_LO_W >= BYTE_W) begin : g_bad_m0
      $error("tmr_count_core: M0_LO_W must lie in 1..BYTE_W-1");
   end
   if (BYTE_W < 2) begin : g_bad_byte
      $error("tmr_count_core: BYTE_W must be at least 2");
   end

   logic [BYTE_W-1:0] nxt_lo, nxt_hi;
   logic              set_lo, set_hi;
   logic [M0_W:0]     m0_sum;
   logic [CNT_W:0]    c16_sum;
   logic [BYTE_W:0]   lo_sum, hi_sum;

   always_comb begin
      m0_sum  = {1'b0, hi, lo[M0_LO_W-1:0]} + M0_ONE;
      c16_sum = {1'b0, hi, lo} + C16_ONE;
      lo_sum  = {1'b0, lo} + B_ONE;
      hi_sum  = {1'b0, hi} + B_ONE;
      nxt_lo  = lo;
      nxt_hi  = hi;
      set_lo  = 1'b0;
      set_hi  = 1'b0;
      if (wr_lo || wr_hi) begin
         if (wr_lo) nxt_lo = wdata;
         if (wr_hi) nxt_hi = wdata;
      end else if (inc) begin
         unique case (mode)
            TM_13B: begin
               nxt_hi = m0_sum[M0_W-1:M0_LO_W];
               nxt_lo = {lo[BYTE_W-1:M0_LO_W], m0_sum[M0_LO_W-1:0]};
               set_lo = m0_sum[M0_W];
            end
            TM_16B: begin
               {nxt_hi, nxt_lo} = c16_sum[CNT_W-1:0];
               set_lo = c16_sum[CNT_W];
            end
            TM_RELOAD: begin
               if (lo_sum[BYTE_W]) begin
                  nxt_lo = hi;
                  set_lo = 1'b1;
               end else begin
                  nxt_lo = lo_sum[BYTE_W-1:0];
               end
            end
            TM_SPLIT: begin
               nxt_lo = lo_sum[BYTE_W-1:0];
               set_lo = lo_sum[BYTE_W];
               nxt_hi = hi_sum[BYTE_W-1:0];
               set_hi = hi_sum[BYTE_W];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo     <= '0;
         hi     <= '0;
         ovf    <= 1'b0;
         ovf_hi <= 1'b0;
      end else begin
         lo <= nxt_lo;
         hi <= nxt_hi;
         if (set_lo)        ovf <= 1'b1;
         else if (flag_clr) ovf <= 1'b0;
         if (set_hi)        ovf_hi <= 1'b1;
         else if (flag_clr) ovf_hi <= 1'b0;
      end
   end

   // R9: a low-byte write lands unchanged
   p_write_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> lo == $past(wdata));
   // R6: 16-bit rollover clears the count and raises the flag
   p_wrap16_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TM_16B && inc && !wr_lo && !wr_hi && {hi, lo} == '1)
      |=> ({hi, lo} == '0 && ovf));
   // R7: reload mode refills the low byte from the high byte
   p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TM_RELOAD && inc && !wr_lo && !wr_hi && lo == '1)
      |=> (lo == $past(hi) && ovf));
   // R7: the high byte never moves in reload mode without a write
   p_reload_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TM_RELOAD && !wr_hi) |=> $stable(hi));
   // R8: split-mode high byte wrap raises its own flag
   p_split_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TM_SPLIT && inc && !wr_lo && !wr_hi && hi == '1) |=> ovf_hi);
   // R10: a clear with no increment drops both flags
   p_flag_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !inc) |=> (!ovf && !ovf_hi));
endmodule

// File: rtl/tmr_dual_byte.sv
module tmr_dual_byte
   import tmr_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int M0_LO_W     = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              evt_pin,
   input  logic              run_en,
   input  logic [1:0]        mode_sel,
   input  logic              evt_sel,
   input  logic              sys_sel,
   input  logic              irq_en,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              flag_clr,
   output logic [BYTE_W-1:0] rd_lo,
   output logic [BYTE_W-1:0] rd_hi,
   output logic              ovf_flag,
   output logic              ovf_hi_flag,
   output logic              irq
);
   logic evt_fall;
   logic inc;

   tmr_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (evt_pin),
      .fall  (evt_fall)
   );

   tmr_src_sel u_src (
      .evt_fall (evt_fall),
      .tick_en  (tick_en),
      .run_en   (run_en),
      .evt_sel  (evt_sel),
      .sys_sel  (sys_sel),
      .inc      (inc)
   );

   tmr_count_core #(.BYTE_W(BYTE_W), .M0_LO_W(M0_LO_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (tmr_mode_e'(mode_sel)),
      .inc      (inc),
      .wr_lo    (wr_lo),
      .wr_hi    (wr_hi),
      .wdata    (wdata),
      .flag_clr (flag_clr),
      .lo       (rd_lo),
      .hi       (rd_hi),
      .ovf      (ovf_flag),
      .ovf_hi   (ovf_hi_flag)
   );

   assign irq = irq_en & (ovf_flag | ovf_hi_flag);

   // R4: idle with no write keeps the count frozen
   p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !wr_lo && !wr_hi) |=> $stable({rd_hi, rd_lo}));
   // R3: in event mode an increment needs a synchronized falling edge
   p_evt_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_sel && !evt_fall && !wr_lo && !wr_hi) |=> $stable({rd_hi, rd_lo}));
endmodule

// File: tb/tb_tmr_dual_byte.sv
module tb_tmr_dual_byte;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0, evt_pin = 1'b1, run_en = 1'b0;
   logic [1:0] mode_sel = 2'b01;
   logic       evt_sel = 1'b0, sys_sel = 1'b1, irq_en = 1'b0;
   logic       wr_lo = 1'b0, wr_hi = 1'b0, flag_clr = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rd_lo, rd_hi;
   logic       ovf_flag, ovf_hi_flag, irq;

   int n_tests = 0, n_fail = 0;
   int m_lo, m_hi, m_f, m_fh;

   always #5 clk = ~clk;

   tmr_dual_byte dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .evt_pin(evt_pin),
      .run_en(run_en), .mode_sel(mode_sel), .evt_sel(evt_sel),
      .sys_sel(sys_sel), .irq_en(irq_en), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .wdata(wdata), .flag_clr(flag_clr), .rd_lo(rd_lo), .rd_hi(rd_hi),
      .ovf_flag(ovf_flag), .ovf_hi_flag(ovf_hi_flag), .irq(irq)
   );

   task automatic check(string req, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic check_all(string req, bit mask_m0);
      check(req, mask_m0 ? int'(rd_lo[4:0]) : int'(rd_lo),
            mask_m0 ? (m_lo % 32) : m_lo);
      check(req, int'(rd_hi), m_hi);
      check(req, int'(ovf_flag), m_f);
      check(req, int'(ovf_hi_flag), m_fh);
   endtask

   task automatic model_inc(int mode);
      int v;
      case (mode)
         0: begin
            v = m_hi * 32 + (m_lo % 32) + 1;
            if (v == 8192) begin v = 0; m_f = 1; end
            m_hi = v / 32;
            m_lo = (m_lo & 8'hE0) | (v % 32);
         end
         1: begin
            v = m_hi * 256 + m_lo + 1;
            if (v == 65536) begin v = 0; m_f = 1; end
            m_hi = v / 256;
            m_lo = v % 256;
         end
         2: begin
            if (m_lo == 255) begin m_lo = m_hi; m_f = 1; end
            else m_lo = m_lo + 1;
         end
         default: begin
            m_lo = m_lo + 1;
            if (m_lo == 256) begin m_lo = 0; m_f = 1; end
            m_hi = m_hi + 1;
            if (m_hi == 256) begin m_hi = 0; m_fh = 1; end
         end
      endcase
   endtask

   task automatic load(int lo, int hi);
      @(negedge clk); wr_lo = 1'b1; wdata = 8'(lo);
      @(negedge clk); wr_lo = 1'b0; wr_hi = 1'b1; wdata = 8'(hi);
      @(negedge clk); wr_hi = 1'b0; flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
      m_lo = lo; m_hi = hi; m_f = 0; m_fh = 0;
   endtask

   task automatic run_sys(int n, int mode);
      @(negedge clk); run_en = 1'b1;
      repeat (n) @(negedge clk);
      run_en = 1'b0;
      for (int i = 0; i < n; i++) model_inc(mode);
   endtask

   initial begin
      #1500000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", int'(rd_lo), 0);
      check("R1", int'(rd_hi), 0);
      check("R1", int'(ovf_flag) + int'(ovf_hi_flag) + int'(irq), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", int'({rd_hi, rd_lo}), 0);

      // R6: 16-bit sweeps across the wrap
      mode_sel = 2'b01;
      for (int s = 0; s < 6; s++) begin
         load(8'hF0 + s * 2, (s % 2 == 0) ? 8'hFF : 8'h12);
         run_sys(5 + s * 4, 1);
         check_all("R6", 1'b0);
      end

      // R5: 13-bit sweeps, upper low-byte bits set as don't-care
      mode_sel = 2'b00;
      for (int s = 0; s < 5; s++) begin
         load(8'hE0 | (24 + s), (s < 3) ? 8'hFF : 8'h7F);
         run_sys(3 + s * 3, 0);
         check_all("R5", 1'b1);
      end

      // R7: reload mode
      mode_sel = 2'b10;
      for (int s = 0; s < 4; s++) begin
         load(8'hF8 + s, 8'hC0 + s * 16);
         run_sys(20 + s * 7, 2);
         check_all("R7", 1'b0);
      end

      // R8: split mode, independent flags
      mode_sel = 2'b11;
      load(8'hFD, 8'hFE);
      run_sys(3, 3);
      check_all("R8", 1'b0);
      load(8'h10, 8'hFC);
      run_sys(6, 3);
      check_all("R8", 1'b0);

      // R11: interrupt gating by enable
      check("R11", int'(irq), 0);
      irq_en = 1'b1;
      @(negedge clk);
      check("R11", int'(irq), 1);

      // R10: clear drops both flags, then irq falls
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
      check("R10", int'(ovf_flag) + int'(ovf_hi_flag), 0);
      check("R11", int'(irq), 0);

      // R10: overflow in the same cycle as a clear wins
      mode_sel = 2'b01;
      load(8'hFF, 8'hFF);
      @(negedge clk); run_en = 1'b1; flag_clr = 1'b1;
      @(negedge clk); run_en = 1'b0; flag_clr = 1'b0;
      check("R10", int'(ovf_flag), 1);
      check("R10", int'({rd_hi, rd_lo}), 0);
      irq_en = 1'b0;

      // R4: run low freezes the count despite a timebase
      load(8'h34, 8'h12);
      repeat (10) @(negedge clk);
      check_all("R4", 1'b0);

      // R9: write wins over an increment in the same cycle
      @(negedge clk); run_en = 1'b1; wr_lo = 1'b1; wdata = 8'h40;
      @(negedge clk); run_en = 1'b0; wr_lo = 1'b0;
      check("R9", int'(rd_lo), 8'h40);
      check("R9", int'(rd_hi), 8'h12);

      // R2: prescaled tick source, one tick every third cycle
      load(8'h00, 8'h00);
      sys_sel = 1'b0;
      @(negedge clk); run_en = 1'b1;
      for (int i = 0; i < 12; i++) begin
         tick_en = (i % 3 == 0);
         @(negedge clk);
      end
      tick_en = 1'b0; run_en = 1'b0;
      check("R2", int'({rd_hi, rd_lo}), 4);
      sys_sel = 1'b1;

      // R3: event edges at the fastest allowed rate, sys clock ignored
      load(8'hFE, 8'h00);
      evt_sel = 1'b1;
      @(negedge clk); run_en = 1'b1;
      for (int k = 0; k < 5; k++) begin
         evt_pin = 1'b0; repeat (2) @(negedge clk);
         evt_pin = 1'b1; repeat (2) @(negedge clk);
      end
      repeat (6) @(negedge clk);
      run_en = 1'b0;
      check("R3", int'({rd_hi, rd_lo}), 16'h0103);
      // R3: a steady pin adds nothing
      @(negedge clk); run_en = 1'b1;
      repeat (10) @(negedge clk);
      run_en = 1'b0;
      check("R3", int'({rd_hi, rd_lo}), 16'h0103);
      evt_sel = 1'b0;

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule